// File: doc/BRIEF.md
# Memory-Mapped Priority Interrupt Controller

This block gathers interrupt requests from up to 31 peripheral devices and presents them to a processor that has only one interrupt input. Each device line is watched for a rising edge; an edge sets a sticky pending bit, so a one-cycle pulse is never lost. The processor sees two 32-bit registers on a simple single-cycle register bus: a pending word and a mask word. The most significant bit of each register is special. In the mask word it is a master switch for the interrupt pin. In the pending word it reads back as a summary flag that is set whenever any unmasked request is waiting.

Supervisor code typically saves the mask word, writes zero to it to hold off new interrupts, reads the pending word, and services sources from bit 0 upward. It then writes the pending word to clear every request and restores the saved mask. That clearing write also returns a one-cycle acknowledge pulse to each device that was pending at the time. A combinational priority output gives the index of the lowest-numbered unmasked pending source, so software or hardware can skip the bit scan.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, both registers read as zero, and the interrupt pin, the acknowledge lines and the priority valid flag are all low.
- R2: A rising edge on request line n sets pending bit n, which stays set after the line falls. A line held high does not set its bit again after a clear until it has first gone low.
- R3: The interrupt pin is high exactly when mask bit 31 is 1 and some bit n in 0..30 is set in both the pending word and the mask word.
- R4: Pending-word bit 31 reads as 1 exactly when some bit in 0..30 is set in both the pending word and the mask word, whatever the value of mask bit 31.
- R5: The priority outputs give valid=1 and the index of the lowest-numbered bit set in both the pending word and the mask word (bit 0 wins over all others), and valid=0 when no such bit exists.
- R6: A write to offset 0 (the pending word) clears every pending bit, whatever the write data.
- R7: In the cycle after a write to offset 0, each acknowledge line n is high for exactly one cycle if and only if pending bit n was set when the write was taken. At all other times the acknowledge lines are low.
- R8: A rising edge that arrives in the same cycle as a write to offset 0 leaves its pending bit set and gets no acknowledge from that write.
- R9: Writing 0 to the mask word (offset 4) drops the interrupt pin without losing pending bits. Writing the saved value back raises the pin again for the requests still pending.
- R10: Reads of offsets other than 0 and 4 return zero, and writes to them change neither register and produce no acknowledge.
- R11: The mask word at offset 4 stores all 32 written bits and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Bus access strobe for this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when not reading |
| req_i | input | 31 | Device request lines, rising-edge sensitive |
| ack_o | output | 31 | One-cycle serviced pulses back to the devices |
| irq_o | output | 1 | Interrupt pin to the processor |
| pend_valid_o | output | 1 | Some unmasked request is pending |
| pend_idx_o | output | 5 | Index of the highest-priority unmasked pending source |

## Verification
The bench targets the cycle where a device edge collides with the clearing write. A design that applied the clear after the set would silently drop that request, and one that acknowledged it early would let the device think it had been serviced. It checks that a line held high is not re-latched after a clear, which a level-sensitive design would get wrong with an interrupt storm. It also checks that the summary bit ignores the master mask bit while the pin does not, and that the priority index picks bit 0 or the lowest unmasked bit even when higher bits are pending and masked. Unmapped offsets are written with live data to show that a loose address decode would corrupt the mask or fire acknowledges.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Byte offsets of the two registers; the handler code depends on them.
    localparam logic [31:0] OFS_PENDING = 32'd0;
    localparam logic [31:0] OFS_MASK    = 32'd4;

    typedef enum logic [1:0] {
        REG_PENDING,
        REG_MASK,
        REG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic clr_pend;
        logic load_mask;
    } wr_ctl_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        if (ofs == OFS_PENDING)   return REG_PENDING;
        else if (ofs == OFS_MASK) return REG_MASK;
        else                      return REG_NONE;
    endfunction

endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
    parameter int N = 31
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic         clr_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] ack_o
);

    logic [N-1:0] req_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] ack_q;
    logic [N-1:0] rise;

    assign rise = req_i & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            pend_q <= '0;
            ack_q  <= '0;
        end else begin
            req_q  <= req_i;
            // a fresh edge wins over a simultaneous clear
            pend_q <= rise | (clr_i ? '0 : pend_q);
            ack_q  <= clr_i ? pend_q : '0;
        end
    end

    assign pend_o = pend_q;
    assign ack_o  = ack_q;

    // R6: after a clear only bits with a fresh edge may remain
    p_clear_wipes_r6: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((pend_q & ~$past(rise)) == '0));

    // R2: without a clear no pending bit is lost
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R7: acknowledges only follow a clearing write
    p_ack_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (ack_q == '0));

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N     = 31,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     vec_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // scan from the top so the lowest set bit is the last one to win
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int N_SRC = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_SRC-1:0]  pend_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              clr_o
);

    reg_sel_e          rsel;
    wr_ctl_t           ctl;
    logic [DATA_W-1:0] mask_q;
    logic              summary;

    assign rsel = decode_ofs(32'(addr_i));

    always_comb begin
        ctl           = '0;
        ctl.clr_pend  = sel_i && wr_i && (rsel == REG_PENDING);
        ctl.load_mask = sel_i && wr_i && (rsel == REG_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst)               mask_q <= '0;
        else if (ctl.load_mask) mask_q <= wdata_i;
    end

    assign summary = |(pend_i & mask_q[N_SRC-1:0]);

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            unique case (rsel)
                REG_PENDING: rdata_o = {summary, pend_i};
                REG_MASK:    rdata_o = mask_q;
                default:     rdata_o = '0;
            endcase
        end
    end

    assign mask_o = mask_q;
    assign clr_o  = ctl.clr_pend;

    // R10: writes outside the map leave the mask alone
    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (sel_i && wr_i && (rsel == REG_NONE)) |=> $stable(mask_q));

    // R11: a mask write stores the full word
    p_mask_load_r11: assert property (@(posedge clk) disable iff (rst)
        (sel_i && wr_i && (rsel == REG_MASK)) |=> (mask_q == $past(wdata_i)));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int N_SRC = DATA_W - 1,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N_SRC-1:0]  req_i,
    output logic [N_SRC-1:0]  ack_o,
    output logic              irq_o,
    output logic              pend_valid_o,
    output logic [IDX_W-1:0]  pend_idx_o
);

    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  masked;
    logic [DATA_W-1:0] mask;
    logic              clr;

    irqc_edge_latch #(.N(N_SRC)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend),
        .ack_o  (ack_o)
    );

    irqc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend),
        .rdata_o (rdata_o),
        .mask_o  (mask),
        .clr_o   (clr)
    );

    assign masked = pend & mask[N_SRC-1:0];

    irqc_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
        .vec_i   (masked),
        .valid_o (pend_valid_o),
        .idx_o   (pend_idx_o)
    );

    assign irq_o = pend_valid_o & mask[DATA_W-1];

    // R5: the chosen source is pending and nothing below it is
    p_prio_lowest_r5: assert property (@(posedge clk) disable iff (rst)
        pend_valid_o |-> (masked[pend_idx_o] &&
                          ((masked & ((N_SRC'(1) << pend_idx_o) - N_SRC'(1))) == '0)));

    // R3: the pin follows the master bit and the unmasked pending set
    p_pin_r3: assert property (@(posedge clk) disable iff (rst)
        irq_o == (mask[DATA_W-1] && (masked != '0)));

    // R1: nothing pending right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (pend == '0 && ack_o == '0 && !irq_o));

endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [30:0] req;
    logic [30:0] ack;
    logic        irq;
    logic        pvalid;
    logic [4:0]  pidx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irqc_top u0 (
        .clk          (clk),
        .rst          (rst),
        .sel_i        (sel),
        .wr_i         (wr),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .req_i        (req),
        .ack_o        (ack),
        .irq_o        (irq),
        .pend_valid_o (pvalid),
        .pend_idx_o   (pidx)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic pulse(input logic [30:0] m);
        @(negedge clk);
        req = req | m;
        @(negedge clk);
        req = req & ~m;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_rd(8'd0, v); chk("R1 pending after reset", v, 32'h0);
        bus_rd(8'd4, v); chk("R1 mask after reset", v, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);
        chk("R1 ack after reset", {1'b0, ack}, 32'h0);
        chk("R1 valid after reset", {31'd0, pvalid}, 32'h0);
    endtask

    task automatic t_latch_and_ack;
        logic [31:0] v;
        pulse(31'h20);
        bus_rd(8'd0, v); chk("R2 pulse latched", v, 32'h20);
        @(negedge clk); req[6] = 1'b1;
        @(negedge clk);
        bus_rd(8'd0, v); chk("R2 level latched", v, 32'h60);
        bus_wr(8'd0, 32'hFFFF_FFFF);
        chk("R7 ack of pending set", {1'b0, ack}, 32'h60);
        @(negedge clk);
        chk("R7 ack lasts one cycle", {1'b0, ack}, 32'h0);
        bus_rd(8'd0, v); chk("R2 held level not relatched", v, 32'h0);
        @(negedge clk); req[6] = 1'b0;
        @(negedge clk);
        bus_rd(8'd0, v); chk("R6 clear any data", v, 32'h0);
    endtask

    task automatic t_gate_and_summary;
        logic [31:0] v;
        bus_wr(8'd4, 32'h0000_0100);
        pulse(31'h100);
        bus_rd(8'd0, v); chk("R4 summary without master", v, 32'h8000_0100);
        chk("R3 pin off without master", {31'd0, irq}, 32'h0);
        chk("R5 index 8", {26'd0, pvalid, pidx}, {26'd0, 1'b1, 5'd8});
        bus_wr(8'd4, 32'h8000_0100);
        chk("R3 pin on with master", {31'd0, irq}, 32'h1);
        bus_wr(8'd0, 32'h0);
        chk("R6 clear with zero data", {31'd0, irq}, 32'h0);
        pulse(31'h200);
        bus_rd(8'd0, v); chk("R4 masked source no summary", v, 32'h0000_0200);
        chk("R3 masked source no pin", {31'd0, irq}, 32'h0);
        chk("R5 masked source not valid", {31'd0, pvalid}, 32'h0);
        bus_wr(8'd0, 32'h0);
    endtask

    task automatic t_priority;
        bus_wr(8'd4, 32'hFFFF_FFFF);
        pulse(31'h4002_0010);
        chk("R5 lowest of 4/17/30", {26'd0, pvalid, pidx}, {26'd0, 1'b1, 5'd4});
        bus_wr(8'd4, 32'h8002_0000);
        chk("R5 masked low bit skipped", {26'd0, pvalid, pidx}, {26'd0, 1'b1, 5'd17});
        bus_wr(8'd4, 32'hFFFF_FFFF);
        bus_wr(8'd0, 32'h0);
        pulse(31'h4000_0000);
        chk("R5 index 30 alone", {26'd0, pvalid, pidx}, {26'd0, 1'b1, 5'd30});
        pulse(31'h1);
        chk("R5 bit 0 highest", {26'd0, pvalid, pidx}, {26'd0, 1'b1, 5'd0});
        bus_wr(8'd0, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        pulse(31'h0C);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 8'd0; wdata = 32'h0;
        req[7] = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        req[7] = 1'b0;
        chk("R8 racing edge not acked", {1'b0, ack}, 32'h0C);
        bus_rd(8'd0, v); chk("R8 racing edge stays pending", v, 32'h8000_0080);
        bus_wr(8'd0, 32'h0);
    endtask

    task automatic t_mask_restore;
        logic [31:0] v;
        bus_wr(8'd4, 32'h8000_00FF);
        pulse(31'h2);
        chk("R9 pin before mask", {31'd0, irq}, 32'h1);
        bus_wr(8'd4, 32'h0);
        chk("R9 pin masked", {31'd0, irq}, 32'h0);
        bus_rd(8'd0, v); chk("R9 pending kept while masked", v, 32'h2);
        bus_wr(8'd4, 32'h8000_00FF);
        chk("R9 pin restored", {31'd0, irq}, 32'h1);
        chk("R9 index restored", {27'd0, pidx}, 32'd1);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        bus_wr(8'd8, 32'hDEAD_BEEF);
        chk("R10 no ack from unmapped", {1'b0, ack}, 32'h0);
        bus_rd(8'd4, v); chk("R10 mask untouched", v, 32'h8000_00FF);
        bus_rd(8'd0, v); chk("R10 pending untouched", v, 32'h8000_0002);
        bus_rd(8'd8, v); chk("R10 read offset 8", v, 32'h0);
        bus_rd(8'h0C, v); chk("R10 read offset 12", v, 32'h0);
        bus_wr(8'd0, 32'h0);
    endtask

    task automatic t_mask_rw;
        logic [31:0] v;
        bus_wr(8'd4, 32'hA5A5_5A5A);
        bus_rd(8'd4, v); chk("R11 mask readback", v, 32'hA5A5_5A5A);
        bus_wr(8'd4, 32'h5A5A_A5A5);
        bus_rd(8'd4, v); chk("R11 mask readback inverse", v, 32'h5A5A_A5A5);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch_and_ack();
        t_gate_and_summary();
        t_priority();
        t_race();
        t_mask_restore();
        t_unmapped();
        t_mask_rw();
        finish_run();
    end

endmodule